// File: doc/BRIEF.md
# Sequential Modular Exponentiator

This block raises an 8-bit unsigned base to an 8-bit unsigned exponent and reduces the result by an 8-bit unsigned modulus. It suits small teaching-scale public-key arithmetic. A single controller walks the exponent from its least significant bit upward. For every bit it squares a running base. For every set bit it also folds the running base into an accumulator that starts at one. The controller stops as soon as no set exponent bits remain.

Every modular product goes through two internal sequential units. The first is a shift-and-add multiplier that forms a 16-bit product in 8 steps. The second is a restoring divider that takes 16 shift-subtract steps and keeps only the remainder. The two units never run at the same time. The caller pulses `start` with the operands present. It then waits for the one-cycle `done_o` pulse and reads `result_o`, together with `err_o`, which is set when the modulus is zero.

Top module: `mexp_top`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `err_o` and `result_o` are all zero.
- R2: For modulus 2 to 255 and a nonzero exponent, the result equals base raised to the exponent, reduced by the modulus, and `err_o` is 0.
- R3: With a nonzero modulus and a zero exponent, the result is 1. `done_o` rises in the second cycle after the start cycle, and no multiply is started.
- R4: A modulus of zero gives result 0 and `err_o` = 1. `done_o` rises in the first cycle after the start cycle. This holds whatever the exponent is.
- R5: A modulus of 1 with a nonzero exponent gives result 0.
- R6: `busy_o` is high from the cycle after the start cycle through the `done_o` cycle. `done_o` is high for exactly one cycle, and `busy_o` is low in the cycle after it.
- R7: `start` is ignored while `busy_o` is high. The running operation completes with its own result, and no extra `done_o` pulse follows.
- R8: Base, exponent and modulus are sampled only in the start cycle. Later changes on these inputs do not affect the running operation.
- R9: A base equal to or larger than the modulus gives the same result as the reduced base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation when idle |
| base_i | input | 8 | Base operand |
| exp_i | input | 8 | Exponent operand |
| mod_i | input | 8 | Modulus operand |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 8 | Result, held until the next operation ends |
| err_o | output | 1 | Set with done when the modulus was zero |

## Verification
The main function is checked with a sweep over every modulus from 2 to 255. Each modulus gets a random base and exponent, so both even and odd moduli and exponents with varied top bits are exercised. Directed cases target particular paths:
- A zero exponent takes the early exit before the loop.
- A zero modulus takes the error path.
- A modulus of 1 forces every remainder to zero.
- A base above the modulus shows that the base is never pre-reduced.
- Exponent 255 runs all eight iterations with the multiply taken on each.
- Exponent 128 runs all eight iterations with the multiply taken only on the last.

Operand changes and extra start pulses during an operation show whether the block captures its inputs once and then ignores `start`.

// File: rtl/mexp_pkg.sv
package mexp_pkg;
  localparam int unsigned DW = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TEST,
    ST_MUL_R,
    ST_RED_R,
    ST_MUL_S,
    ST_RED_S,
    ST_FIN
  } mexp_state_e;
endpackage

// File: rtl/mexp_mul.sv
module mexp_mul #(
  parameter int unsigned W = mexp_pkg::DW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] prod
);
  localparam int unsigned CW = $clog2(W + 1);

  logic [W-1:0]  hi_q, lo_q, mcand_q;
  logic [CW-1:0] cnt_q;
  logic          run_q, done_q;

  // One step: add the multiplicand into the upper half when the low bit is
  // set, then shift the carry/upper/lower chain right by one position.
  function automatic logic [2*W-1:0] f_mul_step(input logic [W-1:0] hi,
                                                input logic [W-1:0] lo,
                                                input logic [W-1:0] mc);
    logic [W:0] acc;
    acc = {1'b0, hi} + (lo[0] ? {1'b0, mc} : '0);
    return {acc, lo[W-1:1]};
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q    <= '0;
      lo_q    <= '0;
      mcand_q <= '0;
      cnt_q   <= '0;
      run_q   <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go) begin
        hi_q    <= '0;
        lo_q    <= op_b;
        mcand_q <= op_a;
        cnt_q   <= CW'(W);
        run_q   <= 1'b1;
      end else if (run_q) begin
        {hi_q, lo_q} <= f_mul_step(hi_q, lo_q, mcand_q);
        cnt_q        <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy = run_q;
  assign done = done_q;
  assign prod = {hi_q, lo_q};
endmodule

// File: rtl/mexp_rem.sv
module mexp_rem #(
  parameter int unsigned W = mexp_pkg::DW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           go,
  input  logic [2*W-1:0] num,
  input  logic [W-1:0]   den,
  output logic           busy,
  output logic           done,
  output logic [W-1:0]   rem
);
  localparam int unsigned NS = 2 * W;
  localparam int unsigned CW = $clog2(NS + 1);

  logic [NS-1:0] dd_q;
  logic [W-1:0]  rm_q, dv_q;
  logic [CW-1:0] cnt_q;
  logic          run_q, done_q;
  logic [W:0]    step_w;

  // One restoring step: bring in the next dividend bit, trial-subtract the
  // divisor, keep the difference only if no borrow. Low bit = quotient bit.
  function automatic logic [W:0] f_div_step(input logic [W-1:0] r,
                                            input logic         nb,
                                            input logic [W-1:0] d);
    logic [W:0] sh;
    logic [W:0] diff;
    sh   = {r, nb};
    diff = sh - {1'b0, d};
    if (sh >= {1'b0, d}) return {diff[W-1:0], 1'b1};
    else                 return {sh[W-1:0], 1'b0};
  endfunction

  assign step_w = f_div_step(rm_q, dd_q[NS-1], dv_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dd_q   <= '0;
      rm_q   <= '0;
      dv_q   <= '0;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go) begin
        dd_q  <= num;
        rm_q  <= '0;
        dv_q  <= den;
        cnt_q <= CW'(NS);
        run_q <= 1'b1;
      end else if (run_q) begin
        rm_q  <= step_w[W:1];
        dd_q  <= {dd_q[NS-2:0], step_w[0]};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy = run_q;
  assign done = done_q;
  assign rem  = rm_q;
endmodule

// File: rtl/mexp_ctrl.sv
module mexp_ctrl
  import mexp_pkg::*;
#(
  parameter int unsigned W = mexp_pkg::DW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [W-1:0]   base,
  input  logic [W-1:0]   expo,
  input  logic [W-1:0]   modu,
  input  logic           mul_done,
  input  logic [2*W-1:0] mul_prod,
  input  logic           rem_done,
  input  logic [W-1:0]   rem_val,
  output logic           mul_go,
  output logic [W-1:0]   mul_a,
  output logic [W-1:0]   mul_b,
  output logic           rem_go,
  output logic [2*W-1:0] rem_num,
  output logic [W-1:0]   rem_den,
  output logic           busy,
  output logic           done,
  output logic [W-1:0]   result,
  output logic           err,
  output logic [W-1:0]   mod_q
);
  mexp_state_e st_q;
  logic [W-1:0] acc_q, sq_q, ex_q, m_q, res_q;
  logic         err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      acc_q <= '0;
      sq_q  <= '0;
      ex_q  <= '0;
      m_q   <= '0;
      res_q <= '0;
      err_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start) begin
          sq_q  <= base;
          ex_q  <= expo;
          m_q   <= modu;
          acc_q <= W'(1);
          if (modu == '0) begin
            res_q <= '0;
            err_q <= 1'b1;
            st_q  <= ST_FIN;
          end else begin
            err_q <= 1'b0;
            st_q  <= ST_TEST;
          end
        end
        ST_TEST: begin
          if (ex_q == '0) begin
            res_q <= acc_q;
            st_q  <= ST_FIN;
          end else if (ex_q[0]) begin
            st_q <= ST_MUL_R;
          end else begin
            st_q <= ST_MUL_S;
          end
        end
        ST_MUL_R: if (mul_done) st_q <= ST_RED_R;
        ST_RED_R: if (rem_done) begin
          acc_q <= rem_val;
          st_q  <= ST_MUL_S;
        end
        ST_MUL_S: if (mul_done) st_q <= ST_RED_S;
        ST_RED_S: if (rem_done) begin
          sq_q <= rem_val;
          ex_q <= ex_q >> 1;
          st_q <= ST_TEST;
        end
        ST_FIN:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // Multiplies are launched from the test state (either kind) or right
  // after the accumulator reduction (the squaring that always follows).
  always_comb begin
    mul_go  = ((st_q == ST_TEST) && (ex_q != '0)) ||
              ((st_q == ST_RED_R) && rem_done);
    mul_a   = ((st_q == ST_TEST) && ex_q[0]) ? acc_q : sq_q;
    mul_b   = sq_q;
    rem_go  = ((st_q == ST_MUL_R) || (st_q == ST_MUL_S)) && mul_done;
    rem_num = mul_prod;
    rem_den = m_q;
  end

  assign busy   = (st_q != ST_IDLE);
  assign done   = (st_q == ST_FIN);
  assign result = res_q;
  assign err    = err_q;
  assign mod_q  = m_q;
endmodule

// File: rtl/mexp_top.sv
module mexp_top #(
  parameter int unsigned W = mexp_pkg::DW
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] base_i,
  input  logic [W-1:0] exp_i,
  input  logic [W-1:0] mod_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] result_o,
  output logic         err_o
);
  logic           mul_go, mul_busy, mul_done;
  logic [W-1:0]   mul_a, mul_b;
  logic [2*W-1:0] mul_prod;
  logic           rem_go, rem_busy, rem_done;
  logic [2*W-1:0] rem_num;
  logic [W-1:0]   rem_den, rem_val, mod_q;

  mexp_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .base(base_i), .expo(exp_i), .modu(mod_i),
    .mul_done(mul_done), .mul_prod(mul_prod),
    .rem_done(rem_done), .rem_val(rem_val),
    .mul_go(mul_go), .mul_a(mul_a), .mul_b(mul_b),
    .rem_go(rem_go), .rem_num(rem_num), .rem_den(rem_den),
    .busy(busy_o), .done(done_o), .result(result_o), .err(err_o),
    .mod_q(mod_q)
  );

  mexp_mul #(.W(W)) u_mul (
    .clk(clk), .rst_n(rst_n), .go(mul_go),
    .op_a(mul_a), .op_b(mul_b),
    .busy(mul_busy), .done(mul_done), .prod(mul_prod)
  );

  mexp_rem #(.W(W)) u_rem (
    .clk(clk), .rst_n(rst_n), .go(rem_go),
    .num(rem_num), .den(rem_den),
    .busy(rem_busy), .done(rem_done), .rem(rem_val)
  );
endmodule

// File: rtl/mexp_chk.sv
module mexp_chk #(
  parameter int unsigned W = mexp_pkg::DW
) (
  input logic         clk,
  input logic         rst_n,
  input logic         busy_o,
  input logic         done_o,
  input logic         err_o,
  input logic [W-1:0] result_o,
  input logic         mul_go,
  input logic         mul_busy,
  input logic         rem_go,
  input logic         rem_busy,
  input logic         rem_done,
  input logic [W-1:0] rem_val,
  input logic [W-1:0] mod_q
);
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_busy_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_o);
  p_done_in_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> busy_o);
  p_busy_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> $past(done_o));
  p_err_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_o) |-> (result_o == '0));
  p_mul_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mul_go |-> !mul_busy);
  p_rem_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rem_go |-> !rem_busy);
  p_units_apart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(mul_busy && rem_busy));
  p_rem_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rem_done |-> (rem_val < mod_q));
endmodule

bind mexp_top mexp_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .done_o(done_o),
  .err_o(err_o), .result_o(result_o),
  .mul_go(mul_go), .mul_busy(mul_busy),
  .rem_go(rem_go), .rem_busy(rem_busy), .rem_done(rem_done),
  .rem_val(rem_val), .mod_q(mod_q)
);

// File: tb/tb_mexp_top.sv
module tb_mexp_top;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT      = 3000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] base_i = '0, exp_i = '0, mod_i = '0;
  logic       busy_o, done_o, err_o;
  logic [7:0] result_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  mexp_top dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .base_i(base_i), .exp_i(exp_i), .mod_i(mod_i),
    .busy_o(busy_o), .done_o(done_o), .result_o(result_o), .err_o(err_o)
  );

  function automatic int ref_pow(int b, int e, int m);
    int acc;
    if (m == 0) return 0;
    acc = 1;
    for (int i = 0; i < e; i++) acc = (acc * b) % m;
    return acc;
  endfunction

  task automatic check(input bit ok, input string req, input int act,
                       input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic launch(input int b, input int e, input int m);
    @(negedge clk);
    base_i = 8'(b); exp_i = 8'(e); mod_i = 8'(m);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int cyc);
    cyc = 1;
    while (!done_o && cyc < LIMIT) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  task automatic run_op(input int b, input int e, input int m,
                        input string req);
    int cyc;
    int exp;
    launch(b, e, m);
    wait_done(cyc);
    exp = ref_pow(b, e, m);
    check(done_o, {req, " done"}, done_o, 1);
    check(result_o == 8'(exp), req, result_o, exp);
    check(err_o == 1'b0, {req, " err"}, err_o, 0);
    @(negedge clk);
  endtask

  task automatic t_reset;
    check(busy_o == 0 && done_o == 0, "R1 busy/done", {busy_o, done_o}, 0);
    check(result_o == 0 && err_o == 0, "R1 result/err", result_o, 0);
  endtask

  task automatic t_exp_zero;
    launch(77, 0, 91);
    check(done_o == 0 && busy_o == 1, "R3 first cycle", done_o, 0);
    @(negedge clk);
    check(done_o == 1, "R3 done second cycle", done_o, 1);
    check(result_o == 1, "R3 result", result_o, 1);
    @(negedge clk);
  endtask

  task automatic t_mod_zero;
    launch(5, 200, 0);
    check(done_o == 1, "R4 done first cycle", done_o, 1);
    check(result_o == 0 && err_o == 1, "R4 result/err", {result_o, err_o}, 1);
    @(negedge clk);
    launch(9, 0, 0);
    check(done_o == 1 && err_o == 1, "R4 zero exponent", {done_o, err_o}, 3);
    @(negedge clk);
  endtask

  task automatic t_mod_one;
    run_op(200, 1, 1, "R5 e=1");
    run_op(13, 255, 1, "R5 e=255");
  endtask

  task automatic t_known;
    run_op(4, 13, 197, "R2 known");
    run_op(255, 255, 253, "R2 all bits");
    run_op(3, 128, 251, "R2 top bit only");
    run_op(0, 7, 10, "R2 zero base");
  endtask

  task automatic t_big_base;
    run_op(250, 11, 17, "R9 base>mod");
    run_op(17, 5, 17, "R9 base=mod");
  endtask

  task automatic t_handshake;
    int cyc;
    launch(7, 200, 233);
    check(busy_o == 1, "R6 busy after start", busy_o, 1);
    wait_done(cyc);
    check(busy_o == 1 && done_o == 1, "R6 busy in done", {busy_o, done_o}, 3);
    @(negedge clk);
    check(busy_o == 0 && done_o == 0, "R6 drop after done",
          {busy_o, done_o}, 0);
  endtask

  task automatic t_capture;
    int cyc;
    launch(6, 77, 143);
    base_i = 8'd99; exp_i = 8'd3; mod_i = 8'd5;
    wait_done(cyc);
    check(result_o == 8'(ref_pow(6, 77, 143)), "R8 captured", result_o,
          ref_pow(6, 77, 143));
    @(negedge clk);
  endtask

  task automatic t_ignore;
    int cyc;
    int extra;
    launch(11, 190, 239);
    repeat (20) @(negedge clk);
    base_i = 8'd2; exp_i = 8'd2; mod_i = 8'd3;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(cyc);
    check(result_o == 8'(ref_pow(11, 190, 239)), "R7 result kept", result_o,
          ref_pow(11, 190, 239));
    extra = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (done_o || busy_o) extra++;
    end
    check(extra == 0, "R7 no extra op", extra, 0);
  endtask

  task automatic t_sweep;
    for (int m = 2; m < 256; m++) begin
      run_op(int'($urandom_range(0, 255)), int'($urandom_range(1, 255)), m,
             "R2 sweep");
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_exp_zero();
    t_mod_zero();
    t_mod_one();
    t_known();
    t_big_base();
    t_handshake();
    t_capture();
    t_ignore();
    t_sweep();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule